// File: doc/BRIEF.md
# Critical-Byte-First Read Cache

This block sits between a CPU bus that reads one byte at a time from a 24-bit byte address and a slow external flash reached through a line-fill engine. It is a direct-mapped, read-only cache with 32-byte lines. A lookup that hits returns its byte combinationally in the same cycle as the request. This holds for repeated accesses to one line and for jumps between lines, so a hit never adds a wait state.

On a miss the cache hands the faulting address, byte offset included, to the fill engine. The engine returns the 32 bytes of that line starting at the faulting byte and wrapping within the line. The CPU stall drops as soon as the wanted byte has been stored. The rest of the line keeps arriving in the background. A per-byte valid vector serves later reads of bytes that have already landed. The line is only marked valid once all 32 bytes are present.

An invalidate input empties the whole cache in one cycle.

Top module: `cbf_cache`

## Requirements
- R1: The cache is direct-mapped over 16 lines. An address splits into byte offset bits [4:0], line index bits [8:5] and tag bits [23:9]. Two addresses with the same index and different tags evict each other.
- R2: After reset every line is invalid. `cpuStall` and `fillReq` are low while `cpuReq` is low, and the first request to any address misses.
- R3: A read that hits keeps `cpuStall` low in the cycle of the request and drives the stored byte on `cpuData` in that cycle. This also holds when consecutive requests alternate between different lines.
- R4: A miss raises `fillReq` for exactly one cycle, with `fillAddr` equal to the full faulting address. The engine then presents the 32 bytes of the line on `fillValid`/`fillData` in the order start offset, start+1, … wrapping modulo 32. Every byte is stored at the offset it belongs to.
- R5: A line becomes valid only after all 32 of its bytes have been stored. A read of a byte of the filling line that has not yet arrived stalls until that byte is stored.
- R6: `cpuStall` for the faulting read drops in the cycle after the requested byte is presented with `fillValid`, not after the last byte of the line.
- R7: While a fill runs, reads of bytes of that line that have already arrived are hits. Reads of any other address stall until the fill completes, and no second `fillReq` is raised during a fill.
- R8: A one-cycle pulse on `invalidate` clears all line-valid bits, so the next read of a previously cached line misses. A fill in progress when the pulse comes still completes, and its line is valid afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpuReq | input | 1 | CPU read request, held until the stall drops |
| cpuAddr | input | 24 | CPU byte address |
| cpuData | output | 8 | Read data, valid when `cpuReq` is high and `cpuStall` low |
| cpuStall | output | 1 | High while the request cannot be served |
| invalidate | input | 1 | Clears every line-valid bit |
| fillReq | output | 1 | One-cycle request to the fill engine |
| fillAddr | output | 24 | Faulting address for the fill, sampled with `fillReq` |
| fillValid | input | 1 | A fill byte is present on `fillData` |
| fillData | input | 8 | Fill byte, in wrapped order from the faulting offset |

## Verification
The bench aims at the wrap order: it reads the faulting byte, the next byte, a byte further on and the byte just before the start offset, while the line is still filling. A design that filled from offset zero, or that released the CPU only at the end of the line, would show stall counts near the line length instead of the latency plus two. Back-to-back hits across two lines would expose any line-switch wait state. Requests to an unrelated cached line during a fill, and a tag conflict differing only in the top address bit, check that other traffic waits and that a mis-split address is caught. An invalidate pulse issued in the middle of a fill separates a design that drops the landing line from one that keeps it.

// File: rtl/cbf_pkg.sv
package cbf_pkg;

  // Strobes from the control FSM to the storage datapath.
  typedef struct packed {
    logic startFill;   // claim the indexed line for a new fill
    logic wrByte;      // store the byte present on the fill bus
    logic finishFill;  // last byte of the line: mark the line valid
  } fillStrobe_t;

endpackage

// File: rtl/cbf_datapath.sv
module cbf_datapath
  import cbf_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  fillStrobe_t       strobe,
  input  logic              invalidate,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic [7:0]        fillData,
  output logic [7:0]        rdData,
  output logic              lineHit,
  output logic              fillMatch,
  output logic              byteReady
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int DEPTH = NUM_LINES * LINE_BYTES;

  logic [OFF_W-1:0] lkOff;
  logic [IDX_W-1:0] lkIdx;
  logic [TAG_W-1:0] lkTag;

  assign lkOff = lookupAddr[OFF_W-1:0];
  assign lkIdx = lookupAddr[OFF_W +: IDX_W];
  assign lkTag = lookupAddr[ADDR_W-1 -: TAG_W];

  logic [7:0]       dataMem [DEPTH];
  logic [TAG_W-1:0] tagMem  [NUM_LINES];
  logic [NUM_LINES-1:0]  lineValid;
  logic [LINE_BYTES-1:0] byteValid;
  logic [IDX_W-1:0] fillIdx;
  logic [TAG_W-1:0] fillTag;
  logic [OFF_W-1:0] fillPtr;

  // Valid bookkeeping and the fill pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      lineValid <= '0;
      byteValid <= '0;
      fillIdx   <= '0;
      fillTag   <= '0;
      fillPtr   <= '0;
    end else begin
      if (invalidate) lineValid <= '0;
      if (strobe.startFill) begin
        fillIdx          <= lkIdx;
        fillTag          <= lkTag;
        fillPtr          <= lkOff;
        byteValid        <= '0;
        lineValid[lkIdx] <= 1'b0;
      end
      if (strobe.wrByte) begin
        byteValid[fillPtr] <= 1'b1;
        fillPtr            <= fillPtr + 1'b1;
      end
      if (strobe.finishFill) lineValid[fillIdx] <= 1'b1;
    end
  end

  // Storage arrays, no reset needed
  always_ff @(posedge clk) begin
    if (strobe.startFill) tagMem[lkIdx] <= lkTag;
    if (strobe.wrByte)    dataMem[{fillIdx, fillPtr}] <= fillData;
  end

  // Same-cycle lookup
  assign rdData    = dataMem[{lkIdx, lkOff}];
  assign lineHit   = lineValid[lkIdx] && (tagMem[lkIdx] == lkTag);
  assign fillMatch = (lkIdx == fillIdx) && (lkTag == fillTag);
  assign byteReady = byteValid[lkOff];

  // Each fill position is written once per line
  AST_NO_DOUBLE_WRITE: assert property (@(posedge clk) disable iff (rst)
    strobe.wrByte |-> !byteValid[fillPtr]); // R4

  // The byte just stored is visible to an unchanged lookup on the next cycle
  AST_BYTE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    ($past(strobe.wrByte) && $stable(lookupAddr) && fillMatch &&
     (lkOff == $past(fillPtr))) |-> byteReady); // R6

  AST_INV_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ($past(invalidate) && !$past(strobe.finishFill)) |-> (lineValid == '0)); // R8

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_lineChk
    AST_LINE_FULL: assert property (@(posedge clk) disable iff (rst)
      $rose(lineValid[g]) |-> ((&byteValid) && (fillIdx == IDX_W'(g)))); // R5
  end

endmodule

// File: rtl/cbf_control.sv
module cbf_control
  import cbf_pkg::*;
#(
  parameter int LINE_BYTES = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cpuReq,
  input  logic        lineHit,
  input  logic        fillMatch,
  input  logic        byteReady,
  input  logic        fillValid,
  output logic        cpuStall,
  output logic        fillReq,
  output fillStrobe_t strobe
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam logic [OFF_W-1:0] LAST_CNT = OFF_W'(LINE_BYTES - 1);

  typedef enum logic { ST_IDLE, ST_FILL } ctrlState_t;

  ctrlState_t       state;
  logic [OFF_W-1:0] byteCnt;
  logic             hit;

  always_comb begin
    hit               = (state == ST_IDLE) ? lineHit : (fillMatch && byteReady);
    cpuStall          = cpuReq && !hit;
    strobe.startFill  = (state == ST_IDLE) && cpuReq && !lineHit;
    strobe.wrByte     = (state == ST_FILL) && fillValid;
    strobe.finishFill = strobe.wrByte && (byteCnt == LAST_CNT);
    fillReq           = strobe.startFill;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      byteCnt <= '0;
    end else begin
      if (strobe.startFill) begin
        state   <= ST_FILL;
        byteCnt <= '0;
      end
      if (strobe.wrByte)     byteCnt <= byteCnt + 1'b1;
      if (strobe.finishFill) state   <= ST_IDLE;
    end
  end

  AST_SINGLE_FILL: assert property (@(posedge clk) disable iff (rst)
    fillReq |=> !fillReq); // R7

  AST_FILL_NO_HIT_STALL: assert property (@(posedge clk) disable iff (rst)
    (cpuReq && fillReq) |-> cpuStall); // R2

endmodule

// File: rtl/cbf_cache.sv
module cbf_cache
  import cbf_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuReq,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic [7:0]        cpuData,
  output logic              cpuStall,
  input  logic              invalidate,
  output logic              fillReq,
  output logic [ADDR_W-1:0] fillAddr,
  input  logic              fillValid,
  input  logic [7:0]        fillData
);
  fillStrobe_t strobe;
  logic lineHit, fillMatch, byteReady;

  assign fillAddr = cpuAddr;

  cbf_control #(.LINE_BYTES(LINE_BYTES)) u_ctrl (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .lineHit(lineHit),
    .fillMatch(fillMatch), .byteReady(byteReady), .fillValid(fillValid),
    .cpuStall(cpuStall), .fillReq(fillReq), .strobe(strobe)
  );

  cbf_datapath #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .NUM_LINES(NUM_LINES)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .invalidate(invalidate),
    .lookupAddr(cpuAddr), .fillData(fillData), .rdData(cpuData),
    .lineHit(lineHit), .fillMatch(fillMatch), .byteReady(byteReady)
  );

endmodule

// File: tb/cbf_cache_bench.sv
module cbf_cache_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        cpuReq;
  logic [23:0] cpuAddr;
  logic [7:0]  cpuData;
  logic        cpuStall;
  logic        invalidate;
  logic        fillReq;
  logic [23:0] fillAddr;
  logic        fillValid;
  logic [7:0]  fillData;

  always #5 clk = ~clk;

  cbf_cache u_cbf_cache (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .cpuStall(cpuStall), .invalidate(invalidate), .fillReq(fillReq),
    .fillAddr(fillAddr), .fillValid(fillValid), .fillData(fillData)
  );

  int checks = 0;
  int fails  = 0;
  int fillLat = 3;
  int fillReqCount = 0;
  logic [23:0] lastFillAddr = '0;

  typedef struct { logic [23:0] addr; logic [7:0] data; string rq; } sbItem_t;
  sbItem_t sbQ[$];

  // Reference flash contents
  function automatic logic [7:0] memByte(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ {a[22:16], a[23]} ^ 8'h3C;
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // Behavioural fill engine: programmable latency, wrapped line order
  logic [23:0] engBase;
  int engStart;
  initial begin
    fillValid = 1'b0;
    fillData  = '0;
    forever begin
      @(negedge clk);
      if (fillReq) begin
        engBase  = {fillAddr[23:5], 5'b0};
        engStart = int'(fillAddr[4:0]);
        lastFillAddr = fillAddr;
        fillReqCount++;
        @(posedge clk);
        repeat (fillLat) @(posedge clk);
        for (int k = 0; k < 32; k++) begin
          #1;
          fillValid = 1'b1;
          fillData  = memByte(engBase | 24'((engStart + k) % 32));
          @(posedge clk);
        end
        #1 fillValid = 1'b0;
      end
    end
  end

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && cpuReq && !cpuStall) begin
        if (sbQ.size() == 0) begin
          check(1'b0, "R3", "unexpected accept", int'(cpuAddr), -1);
        end else begin
          sbItem_t it;
          it = sbQ.pop_front();
          check(cpuData == it.data, it.rq, "read data", int'(cpuData), int'(it.data));
        end
      end
    end
  end

  // Driver: one read, expWait < 0 means no wait-count check
  task automatic rd(input logic [23:0] a, input int expWait, input string rq);
    int w = 0;
    sbQ.push_back('{a, memByte(a), rq});
    cpuAddr = a;
    cpuReq  = 1'b1;
    forever begin
      @(negedge clk);
      if (!cpuStall) break;
      w++;
    end
    if (expWait >= 0) check(w == expWait, rq, "wait cycles", w, expWait);
    @(posedge clk);
    #1 cpuReq = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulseInv();
    invalidate = 1'b1;
    @(posedge clk);
    #1 invalidate = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    int n;
    rst = 1'b1; cpuReq = 1'b0; cpuAddr = '0; invalidate = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!cpuStall, "R2", "stall idle", int'(cpuStall), 0);
    check(!fillReq, "R2", "fillReq idle", int'(fillReq), 0);
    idle(1);

    // Miss at offset 5: released after latency + 2 (R6), fill address (R4)
    fillLat = 3;
    rd(24'h012345, 5, "R6");
    check(lastFillAddr == 24'h012345, "R4", "fill address", int'(lastFillAddr), 24'h012345);
    rd(24'h012346, 0, "R7");   // next byte already landed
    rd(24'h01234A, 3, "R5");   // not yet landed: stalls
    rd(24'h012344, 25, "R4");  // wrapped last byte
    for (int i = 0; i < 32; i++) rd(24'h012340 + 24'(i), 0, "R3");

    // Second line, zero latency
    fillLat = 0;
    rd(24'h0ABC00, 2, "R6");
    check(lastFillAddr == 24'h0ABC00, "R4", "fill address", int'(lastFillAddr), 24'h0ABC00);
    idle(40);
    for (int i = 0; i < 8; i++) begin  // line switching every cycle
      rd(24'h012340 + 24'(i), 0, "R3");
      rd(24'h0ABC00 + 24'(i), 0, "R3");
    end

    // Other line stalls during a fill, no extra fill request
    fillLat = 7;
    n = fillReqCount;
    rd(24'h055567, 9, "R6");
    rd(24'h012350, 30, "R7");
    check(fillReqCount == n + 1, "R7", "fill count", fillReqCount, n + 1);

    // Conflict on tag bit 23, same index
    fillLat = 3;
    rd(24'h812345, 5, "R1");
    rd(24'h012345, 35, "R1");
    idle(40);

    // Invalidate
    pulseInv();
    rd(24'h0ABC03, 5, "R8");
    idle(40);

    // Invalidate during a fill: landing line still valid
    rd(24'h0777E0, 5, "R8");
    pulseInv();
    idle(40);
    rd(24'h0777FF, 0, "R8");
    rd(24'h012345, 5, "R8");
    idle(40);

    check(sbQ.size() == 0, "R3", "pending reads", sbQ.size(), 0);
    summary();
    $finish;
  end

endmodule